// File: doc/BRIEF.md
# Serial Five-Bit Register Loader

This block sits on a CPU write bus that covers a 32 KB address window. Each bus write carries a byte, but only bit 0 and bit 7 of that byte matter. A write with bit 7 clear feeds its bit 0 into a hidden shift register, least significant bit first. The fifth such write moves the collected five-bit value into one of four control registers. Address bits 14:13 of that fifth write select the register. A write with bit 7 set aborts the sequence under way and forces two mode bits of the control register.

The four registers drive the following decoded outputs:
- a nametable arrangement,
- a fixed-slot select, a PRG mode and a CHR mode,
- two CHR bank numbers,
- a PRG bank number and a RAM-disable flag.

A downstream block turns these fields into bank addresses.

The block also drops a write that lands on the cycle directly after an earlier write. This removes the second write of a read-modify-write burst. A register records which CHR bank register was committed most recently. The shift register and the write count are brought out so that the loading progress can be observed.

Top module: `serial_reg_loader`

## Requirements
- R1: After synchronous reset, the outputs hold these values:
  - control fields: arrangement 0, fixed_slot_sel 1, prg_mode 1, chr_mode 0;
  - both CHR banks 0, PRG bank 0, ram_disable 0;
  - last_chr_hi 0, shift register 0, count 0.
- R2: An accepted write with bit 7 = 0 shifts the hidden register right by one. Data bit 0 enters at bit 4. The count rises by one. Data bits 6:1 have no effect.
- R3: The fifth accepted bit write commits the value to the register selected by address bits 14:13 (0 = control, 1 = CHR low, 2 = CHR high, 3 = PRG). The new value is visible on the cycle after that write. The shift register and the count return to 0 at the same time, so the count never exceeds 4.
- R4: The control register decodes as follows:
  - bits 1:0: arrangement (0 = single screen A, 1 = single screen B, 2 = vertical, 3 = horizontal);
  - bit 2: fixed_slot_sel;
  - bit 3: prg_mode;
  - bit 4: chr_mode.
- R5: The CHR low and CHR high registers each present all five committed bits as a bank number. The PRG register presents bits 3:0 as prg_bank and bit 4 as ram_disable.
- R6: An accepted write with bit 7 = 1 has these effects:
  - it clears the shift register and the count;
  - it sets fixed_slot_sel and prg_mode to 1;
  - it leaves every other register bit unchanged;
  - its data bit 0 is not used.
- R7: A write with bit 7 = 0 that arrives on the cycle immediately after any write, accepted or not, is ignored: no output changes. Every write restarts the spacing window. A write two or more cycles after the previous write is accepted.
- R8: A write with bit 7 = 1 is accepted even on the cycle immediately after another write.
- R9: last_chr_hi becomes 0 when the CHR low register is committed and 1 when the CHR high register is committed. Commits to the control or PRG registers leave it unchanged.
- R10: Address bits other than 14:13 have no effect on which register is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | One-cycle strobe per bus write |
| wr_addr | input | ADDR_W (15) | Write address inside the window |
| wr_data | input | 8 | Written byte |
| nt_arrange | output | 2 | Nametable arrangement |
| fixed_slot_sel | output | 1 | Fixed-slot select |
| prg_mode | output | 1 | PRG mode |
| chr_mode | output | 1 | CHR mode |
| chr_bank_lo | output | DATA_W (5) | CHR bank number, low register |
| chr_bank_hi | output | DATA_W (5) | CHR bank number, high register |
| prg_bank | output | 4 | PRG bank number |
| ram_disable | output | 1 | RAM disable flag |
| last_chr_hi | output | 1 | 1 when the CHR high register was committed last |
| dbg_shift | output | DATA_W (5) | Hidden shift register contents |
| dbg_count | output | 3 | Bits collected so far |

## Verification
The bench builds the block with its default parameters: five-bit registers, a fifteen-bit address and a spacing window of two cycles. With a two-cycle window, single-cycle and two-cycle write spacings are both reachable in a few cycles. Chains of three back-to-back writes therefore show that a dropped write still restarts the window. Reset-bit writes placed right after a bit write show the bypass of the spacing filter. A behavioural model tracks write timestamps and every register, and it is compared on each clock.

// File: rtl/serload_pkg.sv
package serload_pkg;

  typedef enum logic [1:0] {
    ARR_ONE_A = 2'd0,
    ARR_ONE_B = 2'd1,
    ARR_VERT  = 2'd2,
    ARR_HORZ  = 2'd3
  } arrange_e;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_CHR_LO = 2'd1,
    SEL_CHR_HI = 2'd2,
    SEL_PRG    = 2'd3
  } reg_sel_e;

  localparam int NUM_REGS  = 4;
  localparam int REG_SEL_W = 2;
  localparam int BYTE_W    = 8;
  localparam int RST_BIT   = 7;

  typedef struct packed {
    logic     chr_mode;
    logic     prg_mode;
    logic     fixed_slot;
    arrange_e arrange;
  } ctrl_fields_t;

  function automatic ctrl_fields_t decode_ctrl(logic [4:0] raw);
    ctrl_fields_t f;
    f.arrange    = arrange_e'(raw[1:0]);
    f.fixed_slot = raw[2];
    f.prg_mode   = raw[3];
    f.chr_mode   = raw[4];
    return f;
  endfunction

endpackage

// File: rtl/serload_gap_filter.sv
module serload_gap_filter #(
  parameter int GAP_CYCLES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic force_bit,
  output logic accept
);
  localparam int AGE_W = $clog2(GAP_CYCLES + 1);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(GAP_CYCLES);

  logic [AGE_W-1:0] age_q;

  function automatic logic spacing_ok(logic [AGE_W-1:0] age);
    return age >= AGE_MAX;
  endfunction

  assign accept = wr_en && (force_bit || spacing_ok(age_q));

  always_ff @(posedge clk) begin
    if (rst)                 age_q <= AGE_MAX;
    else if (wr_en)          age_q <= AGE_W'(1);
    else if (age_q != AGE_MAX) age_q <= age_q + AGE_W'(1);
  end

  // R7
  back_to_back_drop_chk: assert property (@(posedge clk) disable iff (rst)
    ((GAP_CYCLES >= 2) && wr_en && !force_bit && $past(wr_en)) |-> !accept);

  // R8
  force_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && force_bit && $past(wr_en)) |-> accept);

endmodule

// File: rtl/serload_shifter.sv
module serload_shifter #(
  parameter int DATA_W = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       step,
  input  logic                       clear,
  input  logic                       bit_in,
  output logic                       commit,
  output logic [DATA_W-1:0]          commit_val,
  output logic [DATA_W-1:0]          shift_q,
  output logic [$clog2(DATA_W+1)-1:0] count_q
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W - 1);

  function automatic logic [DATA_W-1:0] next_shift(logic [DATA_W-1:0] cur, logic b);
    return {b, cur[DATA_W-1:1]};
  endfunction

  assign commit     = step && (count_q == LAST_CNT);
  assign commit_val = next_shift(shift_q, bit_in);

  always_ff @(posedge clk) begin
    if (rst || clear || commit) begin
      shift_q <= '0;
      count_q <= '0;
    end else if (step) begin
      shift_q <= commit_val;
      count_q <= count_q + CNT_W'(1);
    end
  end

  // R3
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    count_q <= LAST_CNT);

  // R3
  commit_clears_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> (count_q == '0 && shift_q == '0));

  // R6
  clear_empties_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (count_q == '0));

endmodule

// File: rtl/serload_regfile.sv
module serload_regfile
  import serload_pkg::*;
#(
  parameter int          DATA_W      = 5,
  parameter logic [4:0]  CTRL_RST    = 5'h0C,
  parameter bit          RAM_DIS_RST = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         commit,
  input  logic [REG_SEL_W-1:0]         sel,
  input  logic [DATA_W-1:0]            val,
  input  logic                         force_modes,
  output logic [NUM_REGS-1:0][DATA_W-1:0] bank_w,
  output logic                         last_hi_q
);
  localparam logic [DATA_W-1:0] FORCE_MASK = DATA_W'(5'b01100);

  function automatic logic [DATA_W-1:0] rst_val(int idx);
    if (idx == int'(SEL_CTRL)) return DATA_W'(CTRL_RST);
    if (idx == int'(SEL_PRG))  return DATA_W'({RAM_DIS_RST, 4'b0000});
    return '0;
  endfunction

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] r_q;
    always_ff @(posedge clk) begin
      if (rst)
        r_q <= rst_val(i);
      else if (commit && sel == REG_SEL_W'(i))
        r_q <= val;
      else if (force_modes && i == int'(SEL_CTRL))
        r_q <= r_q | FORCE_MASK;
    end
    assign bank_w[i] = r_q;
  end

  always_ff @(posedge clk) begin
    if (rst)
      last_hi_q <= 1'b0;
    else if (commit && sel == SEL_CHR_LO)
      last_hi_q <= 1'b0;
    else if (commit && sel == SEL_CHR_HI)
      last_hi_q <= 1'b1;
  end

  // R6
  force_sets_modes_chk: assert property (@(posedge clk) disable iff (rst)
    force_modes |=> (bank_w[SEL_CTRL][3:2] == 2'b11));

  // R6
  force_keeps_banks_chk: assert property (@(posedge clk) disable iff (rst)
    force_modes |=> $stable(bank_w[SEL_CHR_HI]));

  // R9
  last_hi_set_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && sel == SEL_CHR_HI) |=> last_hi_q);

  // R9
  last_lo_set_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && sel == SEL_CHR_LO) |=> !last_hi_q);

endmodule

// File: rtl/serial_reg_loader.sv
module serial_reg_loader
  import serload_pkg::*;
#(
  parameter int         ADDR_W      = 15,
  parameter int         DATA_W      = 5,
  parameter int         GAP_CYCLES  = 2,
  parameter logic [4:0] CTRL_RST    = 5'h0C,
  parameter bit         RAM_DIS_RST = 1'b0
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [7:0]                   wr_data,
  output logic [1:0]                   nt_arrange,
  output logic                         fixed_slot_sel,
  output logic                         prg_mode,
  output logic                         chr_mode,
  output logic [DATA_W-1:0]            chr_bank_lo,
  output logic [DATA_W-1:0]            chr_bank_hi,
  output logic [3:0]                   prg_bank,
  output logic                         ram_disable,
  output logic                         last_chr_hi,
  output logic [DATA_W-1:0]            dbg_shift,
  output logic [$clog2(DATA_W+1)-1:0]  dbg_count
);
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int SEL_LO = ADDR_W - REG_SEL_W;

  logic accept, accept_bit, accept_rst, commit;
  logic [DATA_W-1:0] commit_val;
  logic [NUM_REGS-1:0][DATA_W-1:0] bank_w;
  logic [REG_SEL_W-1:0] sel;
  ctrl_fields_t cf;

  assign sel        = wr_addr[ADDR_W-1:SEL_LO];
  assign accept_bit = accept && !wr_data[RST_BIT];
  assign accept_rst = accept &&  wr_data[RST_BIT];

  serload_gap_filter #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .force_bit(wr_data[RST_BIT]), .accept(accept)
  );

  serload_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .step(accept_bit), .clear(accept_rst),
    .bit_in(wr_data[0]), .commit(commit), .commit_val(commit_val),
    .shift_q(dbg_shift), .count_q(dbg_count)
  );

  serload_regfile #(.DATA_W(DATA_W), .CTRL_RST(CTRL_RST),
                    .RAM_DIS_RST(RAM_DIS_RST)) u_regs (
    .clk(clk), .rst(rst), .commit(commit), .sel(sel), .val(commit_val),
    .force_modes(accept_rst), .bank_w(bank_w), .last_hi_q(last_chr_hi)
  );

  assign cf             = decode_ctrl(bank_w[SEL_CTRL][4:0]);
  assign nt_arrange     = cf.arrange;
  assign fixed_slot_sel = cf.fixed_slot;
  assign prg_mode       = cf.prg_mode;
  assign chr_mode       = cf.chr_mode;
  assign chr_bank_lo    = bank_w[SEL_CHR_LO];
  assign chr_bank_hi    = bank_w[SEL_CHR_HI];
  assign prg_bank       = bank_w[SEL_PRG][3:0];
  assign ram_disable    = bank_w[SEL_PRG][4];

  // R2
  bit_step_count_chk: assert property (@(posedge clk) disable iff (rst)
    (accept_bit && !commit) |=> (dbg_count == $past(dbg_count) + CNT_W'(1)));

  // R7
  dropped_write_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !accept) |=> ($stable(dbg_count) && $stable(chr_bank_lo)));

endmodule

// File: tb/serial_reg_loader_tb.sv
module serial_reg_loader_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  nt_arrange;
  logic        fixed_slot_sel, prg_mode, chr_mode, ram_disable, last_chr_hi;
  logic [4:0]  chr_bank_lo, chr_bank_hi, dbg_shift;
  logic [3:0]  prg_bank;
  logic [2:0]  dbg_count;

  int errors = 0, checks = 0;
  bit done = 0, compare_on = 0;

  always #4 clk = ~clk;

  serial_reg_loader u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .nt_arrange(nt_arrange), .fixed_slot_sel(fixed_slot_sel), .prg_mode(prg_mode),
    .chr_mode(chr_mode), .chr_bank_lo(chr_bank_lo), .chr_bank_hi(chr_bank_hi),
    .prg_bank(prg_bank), .ram_disable(ram_disable), .last_chr_hi(last_chr_hi),
    .dbg_shift(dbg_shift), .dbg_count(dbg_count)
  );

  // behavioural model
  int cyc = 0, last_wr = -100;
  int m_shift = 0, m_cnt = 0, m_ctrl = 12, m_lo = 0, m_hi = 0, m_prg = 0, m_last = 0;

  always @(posedge clk) begin
    if (rst) begin
      last_wr = -100; m_shift = 0; m_cnt = 0; m_ctrl = 12;
      m_lo = 0; m_hi = 0; m_prg = 0; m_last = 0;
    end else if (wr_en) begin
      if (wr_data[7]) begin
        m_shift = 0; m_cnt = 0; m_ctrl = m_ctrl | 12;
      end else if (cyc - last_wr >= 2) begin
        m_shift = (m_shift / 2) + (wr_data[0] ? 16 : 0);
        m_cnt = m_cnt + 1;
        if (m_cnt == 5) begin
          case (wr_addr / 8192)
            0: m_ctrl = m_shift;
            1: begin m_lo = m_shift; m_last = 0; end
            2: begin m_hi = m_shift; m_last = 1; end
            default: m_prg = m_shift;
          endcase
          m_shift = 0; m_cnt = 0;
        end
      end
      last_wr = cyc;
    end
    cyc = cyc + 1;
  end

  task automatic chk(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at t=%0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (compare_on && !rst) begin
      chk("R4 arrangement", nt_arrange, m_ctrl % 4);
      chk("R4 mode bits", {chr_mode, prg_mode, fixed_slot_sel}, m_ctrl / 4);
      chk("R5 chr low", chr_bank_lo, m_lo);
      chk("R5 chr high", chr_bank_hi, m_hi);
      chk("R5 prg bank", prg_bank, m_prg % 16);
      chk("R5 ram disable", ram_disable, m_prg / 16);
      chk("R9 last chr", last_chr_hi, m_last);
      chk("R2 shift", dbg_shift, m_shift);
      chk("R3 count", dbg_count, m_cnt);
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(logic [14:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // five spaced bit writes, junk in data bits 6:1
  task automatic load(logic [14:0] a, logic [4:0] v);
    for (int i = 0; i < 5; i++) begin
      wr(a, {1'b0, 6'(7'h2D + i * 9), v[i]});
      idle(1);
    end
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctrl", {chr_mode, prg_mode, fixed_slot_sel, nt_arrange}, 12);
    chk("R1 banks", {chr_bank_lo, chr_bank_hi, prg_bank, ram_disable}, 0);
    chk("R1 debug", {last_chr_hi, dbg_shift, dbg_count}, 0);
    compare_on = 1;

    // R2 single bit shift
    wr(15'h2000, 8'h7F);
    chk("R2 first bit at bit4", dbg_shift, 16);
    chk("R2 count one", dbg_count, 1);
    idle(1);
    for (int i = 0; i < 4; i++) begin wr(15'h2000, 8'h00); idle(1); end
    chk("R3 commit lo", chr_bank_lo, 5'b00001);

    // R3/R5 each register
    load(15'h2000, 5'b10110);
    chk("R5 chr low value", chr_bank_lo, 22);
    chk("R9 after lo", last_chr_hi, 0);
    load(15'h4000, 5'b01101);
    chk("R5 chr high value", chr_bank_hi, 13);
    chk("R9 after hi", last_chr_hi, 1);
    load(15'h6000, 5'b11010);
    chk("R5 prg value", prg_bank, 10);
    chk("R5 ram disable", ram_disable, 1);
    chk("R9 unchanged by prg", last_chr_hi, 1);
    // R4 each arrangement
    for (int k = 0; k < 4; k++) begin
      load(15'h0000, 5'(16 + k));
      chk("R4 arrangement sweep", nt_arrange, k);
      chk("R4 chr_mode", chr_mode, 1);
      chk("R4 prg/slot cleared", {prg_mode, fixed_slot_sel}, 0);
    end

    // R10 low address bits ignored
    load(15'h5ABC, 5'b00111);
    chk("R10 sel high via 5ABC", chr_bank_hi, 7);
    load(15'h3FFF, 5'b11100);
    chk("R10 sel low via 3FFF", chr_bank_lo, 28);
    chk("R9 after lo again", last_chr_hi, 0);

    // R7 back-to-back drop and window restart
    wr(15'h2000, 8'h01);
    wr(15'h2000, 8'h01);
    chk("R7 second dropped", dbg_count, 1);
    wr(15'h2000, 8'h01);
    chk("R7 third dropped (window restart)", dbg_count, 1);
    idle(1);
    wr(15'h2000, 8'h01);
    chk("R7 spaced accepted", dbg_count, 2);
    idle(1);

    // R6/R8 reset bit right after a write
    wr(15'h2000, 8'h01);
    wr(15'h4000, 8'h81);
    chk("R8 reset bit accepted", dbg_count, 0);
    chk("R6 shift cleared", dbg_shift, 0);
    chk("R6 modes forced", {prg_mode, fixed_slot_sel}, 3);
    chk("R6 chr_mode kept", chr_mode, 1);
    chk("R6 arrangement kept", nt_arrange, 3);
    chk("R6 chr high kept", chr_bank_hi, 7);
    idle(1);
    // sequence restarts from empty
    wr(15'h2000, 8'h00); idle(1);
    wr(15'h2000, 8'h01); idle(1);
    wr(15'h2000, 8'h80);
    chk("R6 mid-sequence abort", dbg_count, 0);
    idle(1);
    load(15'h2000, 5'b01011);
    chk("R3 full load after abort", chr_bank_lo, 11);
    // rapid reset-bit writes
    wr(15'h0000, 8'h80);
    wr(15'h0000, 8'hFF);
    chk("R8 consecutive reset bits", {prg_mode, fixed_slot_sel, dbg_count}, 5'b11000);
    idle(3);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule